// File: doc/BRIEF.md
# Interrupt Source Event-State Controller

This block keeps a two-bit event state for each of `NUM_SRC` interrupt sources and turns raw source activity into source-number notifications for a downstream router. Message-type sources fire on single-cycle trigger pulses or on a store to their trigger page. Level-type sources fire when their input line rises. Repeat events are merged: a source that has already been forwarded only records that another event came in. It is not notified again until software signals end-of-interrupt (EOI).

Software reaches the state through an address-decoded load/store port. Each source owns a page of `2^PAGE_SHIFT` bytes at `n << PAGE_SHIFT`. Bits [11:8] of the address inside the management area pick the operation. Every load returns the state as it was before the access. When `PAGE_SHIFT` is 13 or 17, each page splits in two: the lower half triggers the source and the upper half manages it. When `PAGE_SHIFT` is 12 or 16, one page does both. Notifications come out one per cycle on `notify_valid`/`notify_src`.

Top module: `pq_event_ctrl`

## Requirements
- R1: After reset, every source reads state 00, `notify_valid` and `rsp_valid` are low, and a state read returns 0 in every data bit.
- R2: A trigger on a source in state 00 (P=bit1, Q=bit0) moves it to 10. A trigger sampled at clock edge k makes `notify_valid` high, with that source's index on `notify_src`, for exactly one cycle after edge k+1.
- R3: A trigger on a source in state 10 or 11 moves it to 11 and produces no notification.
- R4: A trigger on a source in state 01 (off) leaves it at 01 and produces no notification.
- R5: A load at management offset 0x000 is an EOI. It moves 11 to 10 and issues a new notification, moves 10 to 00, and leaves 00 and 01 unchanged. Its returned data is 1 exactly when a new notification was issued, and 0 otherwise.
- R6: A load at offset 0x800 returns the previous state in bits [1:0] and changes nothing. Loads at 0xC00, 0xD00, 0xE00 and 0xF00 set the state to 00, 01, 10 and 11 and return the previous state. Every load answers with `rsp_valid` one cycle later.
- R7: With `STORE_EOI_EN` = 1, a store at offset 0x400 performs the same EOI state change as R5. Stores never raise `rsp_valid`.
- R8: In two-page mode, source n's trigger page starts at `n << PAGE_SHIFT` and its management page at that base plus `2^(PAGE_SHIFT-1)`. A store to the trigger page of a message-type source acts as a trigger.
- R9: A source marked in `LEVEL_MAP` is triggered only by a rising edge on its `lvl_in` bit. Its `msi_trig` bit and stores to its trigger page have no effect.
- R10: An EOI on a level-type source whose line is still high and whose P bit is clear after the EOI sets the state to 10, issues a notification and returns 1.
- R11: A load whose source index is `NUM_SRC` or higher returns all ones. No access to such an index changes any state or causes a notification.
- R12: Notifications raised in the same cycle come out on consecutive cycles, lowest source index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the access |
| rsp_valid | output | 1 | Load data valid, one cycle after the load |
| rsp_data | output | DATA_W | Load result |
| msi_trig | input | NUM_SRC | Per-source trigger pulses for message-type sources |
| lvl_in | input | NUM_SRC | Per-source input lines for level-type sources |
| notify_valid | output | 1 | Notification strobe to the router |
| notify_src | output | SRC_W | Index of the notified source |

## Verification
A load takes effect on the edge that samples it, so its data is read at the next falling edge. A state change caused by an event or by an access is therefore visible to any later access. A notification passes through one more register than the state does, so the bench checks one trigger cycle by cycle: low one falling edge after the trigger, high at the next, low again after that. Every other notification is counted, and its order and cycle recorded, by a falling-edge monitor; the bench reads those counts only after a settling gap of several cycles. Merging, level re-notification and out-of-range silence are judged by whether those counts grew.

// File: rtl/pq_pkg.sv
package pq_pkg;
   typedef enum logic [2:0] {
      OP_NONE,
      OP_GET,
      OP_EOI,
      OP_SET,
      OP_TRIG
   } pq_op_e;

   localparam logic [1:0] PQ_IDLE   = 2'b00;
   localparam logic [1:0] PQ_OFF    = 2'b01;
   localparam logic [1:0] PQ_PEND   = 2'b10;
   localparam logic [1:0] PQ_QUEUED = 2'b11;
endpackage

// File: rtl/pq_addr_dec.sv
module pq_addr_dec
   import pq_pkg::*;
#(
   parameter int NUM_SRC      = 8,
   parameter int PAGE_SHIFT   = 13,
   parameter int ADDR_W       = 32,
   parameter bit STORE_EOI_EN = 1'b1,
   localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam int IDX_W = ADDR_W - PAGE_SHIFT
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              write,
   output logic [SRC_W-1:0]  src_idx,
   output logic              in_range,
   output pq_op_e            op,
   output logic [1:0]        set_val
);
   localparam bit TWO_PAGE = (PAGE_SHIFT == 13) || (PAGE_SHIFT == 17);

   logic [IDX_W-1:0] idx_full;
   logic             mgmt;
   logic [1:0]       off_sel;
   logic             unused_addr;

   assign idx_full    = addr[ADDR_W-1:PAGE_SHIFT];
   assign in_range    = idx_full < IDX_W'(NUM_SRC);
   assign src_idx     = idx_full[SRC_W-1:0];
   assign off_sel     = addr[11:10];
   assign set_val     = addr[9:8];
   assign unused_addr = ^addr;

   generate
      if (TWO_PAGE) begin : g_split
         assign mgmt = addr[PAGE_SHIFT-1];
      end else begin : g_single
         assign mgmt = 1'b1;
      end
   endgenerate

   always_comb begin
      op = OP_NONE;
      if (in_range) begin
         if (!write) begin
            if (!mgmt)                op = OP_GET;
            else if (off_sel == 2'b00) op = OP_EOI;
            else if (off_sel == 2'b11) op = OP_SET;
            else                       op = OP_GET;
         end else begin
            if (!mgmt)                 op = OP_TRIG;
            else if (off_sel == 2'b01) op = STORE_EOI_EN ? OP_EOI : OP_NONE;
            else if (!TWO_PAGE)        op = OP_TRIG;
            else                       op = OP_NONE;
         end
      end
   end
endmodule

// File: rtl/pq_cell.sv
module pq_cell
   import pq_pkg::*;
#(
   parameter bit IS_LEVEL = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_sel,
   input  pq_op_e     bus_op,
   input  logic [1:0] set_val,
   input  logic       msi_trig,
   input  logic       lvl_in,
   output logic [1:0] pq_o,
   output logic       notify_o,
   output logic       renotify_o
);
   logic [1:0] pq_q, s_op, s_nx;
   logic       line_q, trig, eoi_ntf, trg_ntf;

   generate
      if (IS_LEVEL) begin : g_level
         logic unused_msi;
         assign unused_msi = msi_trig;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_q <= 1'b0;
            else        line_q <= lvl_in;
         end
         assign trig = lvl_in & ~line_q;
      end else begin : g_msg
         logic unused_lvl;
         assign unused_lvl = lvl_in;
         assign line_q     = 1'b0;
         assign trig       = msi_trig | (bus_sel && bus_op == OP_TRIG);
      end
   endgenerate

   always_comb begin
      s_op    = pq_q;
      eoi_ntf = 1'b0;
      if (bus_sel) begin
         case (bus_op)
            OP_EOI: begin
               if (pq_q == PQ_QUEUED) begin
                  s_op    = PQ_PEND;
                  eoi_ntf = 1'b1;
               end else if (pq_q == PQ_PEND) begin
                  s_op = PQ_IDLE;
               end
               if (IS_LEVEL && s_op == PQ_IDLE && line_q) begin
                  s_op    = PQ_PEND;
                  eoi_ntf = 1'b1;
               end
            end
            OP_SET:  s_op = set_val;
            default: ;
         endcase
      end
      s_nx    = s_op;
      trg_ntf = 1'b0;
      if (trig) begin
         case (s_op)
            PQ_IDLE: begin
               s_nx    = PQ_PEND;
               trg_ntf = 1'b1;
            end
            PQ_PEND, PQ_QUEUED: s_nx = PQ_QUEUED;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pq_q <= PQ_IDLE;
      else        pq_q <= s_nx;
   end

   assign pq_o       = pq_q;
   assign notify_o   = eoi_ntf | trg_ntf;
   assign renotify_o = eoi_ntf;

   assert_trig_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_sel && trig && pq_q == PQ_IDLE) |=> (pq_q == PQ_PEND));
   assert_merge_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_sel && trig && pq_q[1]) |-> !notify_o);
   assert_merge_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_sel && trig && pq_q[1]) |=> (pq_q == PQ_QUEUED));
   assert_off_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_sel && pq_q == PQ_OFF) |=> (pq_q == PQ_OFF));
   assert_eoi_requeue_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_op == OP_EOI && pq_q == PQ_QUEUED) |-> renotify_o);
endmodule

// File: rtl/pq_notify_arb.sv
module pq_notify_arb #(
   parameter int NUM_SRC = 8,
   localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_in,
   output logic               notify_valid,
   output logic [SRC_W-1:0]   notify_src
);
   logic [NUM_SRC-1:0] pend_q, gnt_oh;
   logic [SRC_W-1:0]   gnt_idx;

   always_comb begin
      gnt_idx = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pend_q[i]) gnt_idx = SRC_W'(i);
      end
      gnt_oh          = '0;
      gnt_oh[gnt_idx] = |pend_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q       <= '0;
         notify_valid <= 1'b0;
         notify_src   <= '0;
      end else begin
         pend_q       <= (pend_q & ~gnt_oh) | req_in;
         notify_valid <= |pend_q;
         notify_src   <= gnt_idx;
      end
   end

   assert_drain_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (|pend_q) |=> notify_valid);
   assert_src_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
      notify_valid |-> (int'(notify_src) < NUM_SRC));
endmodule

// File: rtl/pq_event_ctrl.sv
module pq_event_ctrl
   import pq_pkg::*;
#(
   parameter int                 NUM_SRC      = 8,
   parameter int                 PAGE_SHIFT   = 13,
   parameter int                 ADDR_W       = 32,
   parameter int                 DATA_W       = 64,
   parameter bit                 STORE_EOI_EN = 1'b1,
   parameter logic [NUM_SRC-1:0] LEVEL_MAP    = '0,
   localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  rsp_data,
   input  logic [NUM_SRC-1:0] msi_trig,
   input  logic [NUM_SRC-1:0] lvl_in,
   output logic               notify_valid,
   output logic [SRC_W-1:0]   notify_src
);
   generate
      if (!(PAGE_SHIFT == 12 || PAGE_SHIFT == 13 || PAGE_SHIFT == 16 || PAGE_SHIFT == 17)) begin : g_bad_shift
         $error("PAGE_SHIFT must be 12, 13, 16 or 17");
      end
      if (NUM_SRC < 2) begin : g_bad_num
         $error("NUM_SRC must be at least 2");
      end
      if (ADDR_W - PAGE_SHIFT <= SRC_W) begin : g_bad_addr
         $error("ADDR_W too small for NUM_SRC pages");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
   endgenerate

   logic [SRC_W-1:0]   src_idx;
   logic               in_range;
   pq_op_e             op;
   logic [1:0]         set_val;
   logic [1:0]         pq_arr [NUM_SRC];
   logic [NUM_SRC-1:0] ntf_vec, renot_vec;

   pq_addr_dec #(
      .NUM_SRC(NUM_SRC), .PAGE_SHIFT(PAGE_SHIFT),
      .ADDR_W(ADDR_W), .STORE_EOI_EN(STORE_EOI_EN)
   ) u_dec (
      .addr(req_addr), .write(req_write), .src_idx(src_idx),
      .in_range(in_range), .op(op), .set_val(set_val)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      pq_cell #(.IS_LEVEL(LEVEL_MAP[i])) u_cell (
         .clk(clk), .rst_n(rst_n),
         .bus_sel(req_valid && in_range && (src_idx == SRC_W'(i))),
         .bus_op(op), .set_val(set_val),
         .msi_trig(msi_trig[i]), .lvl_in(lvl_in[i]),
         .pq_o(pq_arr[i]), .notify_o(ntf_vec[i]), .renotify_o(renot_vec[i])
      );
   end

   pq_notify_arb #(.NUM_SRC(NUM_SRC)) u_arb (
      .clk(clk), .rst_n(rst_n), .req_in(ntf_vec),
      .notify_valid(notify_valid), .notify_src(notify_src)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= req_valid && !req_write;
         if (req_valid && !req_write) begin
            if (!in_range)         rsp_data <= '1;
            else if (op == OP_EOI) rsp_data <= DATA_W'(renot_vec[src_idx]);
            else                   rsp_data <= DATA_W'(pq_arr[src_idx]);
         end
      end
   end

   assert_load_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid);
   assert_store_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> !rsp_valid);
   assert_oor_ones_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !in_range) |=> (rsp_data == {DATA_W{1'b1}}));
endmodule

// File: tb/pq_event_ctrl_tb.sv
module pq_event_ctrl_tb;
   localparam int NSRC = 8;
   localparam int SH   = 13;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic        rsp_valid;
   logic [63:0] rsp_data;
   logic [7:0]  msi_trig = '0, lvl_in = '0;
   logic        notify_valid;
   logic [2:0]  notify_src;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int ntf_cnt [NSRC];
   int log_src [64];
   int log_cyc [64];
   int log_n = 0;

   always #10 clk = ~clk;

   pq_event_ctrl #(
      .NUM_SRC(NSRC), .PAGE_SHIFT(SH), .ADDR_W(32), .DATA_W(64),
      .STORE_EOI_EN(1'b1), .LEVEL_MAP(8'hC0)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .msi_trig(msi_trig), .lvl_in(lvl_in),
      .notify_valid(notify_valid), .notify_src(notify_src)
   );

   initial for (int i = 0; i < NSRC; i++) ntf_cnt[i] = 0;

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && notify_valid) begin
         ntf_cnt[notify_src] = ntf_cnt[notify_src] + 1;
         if (log_n < 64) begin
            log_src[log_n] = int'(notify_src);
            log_cyc[log_n] = cyc;
         end
         log_n = log_n + 1;
      end
   end

   function automatic logic [31:0] mg(input int n);
      return (32'(n) << SH) | (32'd1 << (SH - 1));
   endfunction
   function automatic logic [31:0] tp(input int n);
      return 32'(n) << SH;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic ld(input logic [31:0] a, output logic [63:0] d, output logic v);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      v = rsp_valid; d = rsp_data;
      req_valid = 1'b0;
   endtask

   task automatic st(input logic [31:0] a, output logic v);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a;
      @(negedge clk);
      v = rsp_valid;
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic get_chk(input string tag, input int n, input logic [1:0] exp);
      logic [63:0] d; logic v;
      ld(mg(n) | 32'h800, d, v);
      chk({tag, " get"}, d, {62'd0, exp});
   endtask

   task automatic pulse(input logic [7:0] m);
      @(negedge clk); msi_trig = m;
      @(negedge clk); msi_trig = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 notify_valid", notify_valid, 0);
      chk("R1 rsp_valid", rsp_valid, 0);
      for (int i = 0; i < NSRC; i++) get_chk("R1", i, 2'b00);
   endtask

   task automatic t_trigger;
      @(negedge clk); msi_trig = 8'h04;
      @(negedge clk); msi_trig = '0;
      chk("R2 notify early", notify_valid, 0);
      @(negedge clk);
      chk("R2 notify due", notify_valid, 1);
      chk("R2 notify_src", notify_src, 2);
      @(negedge clk);
      chk("R2 notify single", notify_valid, 0);
      get_chk("R2", 2, 2'b10);
   endtask

   task automatic t_merge;
      pulse(8'h04); pulse(8'h04); idle(3);
      get_chk("R3", 2, 2'b11);
      chk("R3 no extra notify", ntf_cnt[2], 1);
   endtask

   task automatic t_eoi;
      logic [63:0] d; logic v;
      ld(mg(2), d, v);
      chk("R5 eoi 11 ret", d, 1);
      idle(3);
      chk("R5 renotify", ntf_cnt[2], 2);
      get_chk("R5 11->10", 2, 2'b10);
      ld(mg(2), d, v);
      chk("R5 eoi 10 ret", d, 0);
      idle(3);
      get_chk("R5 10->00", 2, 2'b00);
      chk("R5 no notify", ntf_cnt[2], 2);
   endtask

   task automatic t_off;
      logic [63:0] d; logic v;
      ld(mg(3) | 32'hD00, d, v);
      chk("R6 set01 ret", d, 0);
      pulse(8'h08); idle(3);
      get_chk("R4 trig off", 3, 2'b01);
      chk("R4 no notify", ntf_cnt[3], 0);
      ld(mg(3), d, v);
      chk("R5 eoi off ret", d, 0);
      get_chk("R5 off kept", 3, 2'b01);
   endtask

   task automatic t_set;
      logic [63:0] d; logic v;
      ld(mg(4) | 32'hF00, d, v);
      chk("R6 set11 ret", d, 0);
      chk("R6 rsp_valid", v, 1);
      ld(mg(4) | 32'hE00, d, v);
      chk("R6 set10 ret", d, 3);
      ld(mg(4) | 32'hC00, d, v);
      chk("R6 set00 ret", d, 2);
      get_chk("R6", 4, 2'b00);
      chk("R6 set no notify", ntf_cnt[4], 0);
   endtask

   task automatic t_store_eoi;
      logic v;
      pulse(8'h20); pulse(8'h20); idle(2);
      get_chk("R7 pre", 5, 2'b11);
      st(mg(5) | 32'h400, v);
      chk("R7 store no rsp", v, 0);
      idle(3);
      get_chk("R7 11->10", 5, 2'b10);
      chk("R7 renotify", ntf_cnt[5], 2);
   endtask

   task automatic t_trig_page;
      logic v;
      st(tp(1), v);
      idle(3);
      get_chk("R8 trig page", 1, 2'b10);
      chk("R8 notify", ntf_cnt[1], 1);
   endtask

   task automatic t_level;
      logic [63:0] d; logic v;
      pulse(8'h40);
      st(tp(6), v);
      idle(3);
      get_chk("R9 ignored", 6, 2'b00);
      chk("R9 no notify", ntf_cnt[6], 0);
      @(negedge clk); lvl_in[6] = 1'b1;
      idle(3);
      chk("R9 edge notify", ntf_cnt[6], 1);
      get_chk("R9 pending", 6, 2'b10);
      ld(mg(6), d, v);
      chk("R10 eoi high ret", d, 1);
      idle(3);
      chk("R10 renotify", ntf_cnt[6], 2);
      get_chk("R10 state", 6, 2'b10);
      @(negedge clk); lvl_in[6] = 1'b0;
      idle(2);
      ld(mg(6), d, v);
      chk("R10 eoi low ret", d, 0);
      idle(3);
      get_chk("R10 cleared", 6, 2'b00);
      chk("R10 no notify", ntf_cnt[6], 2);
   endtask

   task automatic t_oor;
      logic [63:0] d; logic v;
      int base;
      base = log_n;
      ld(mg(8) | 32'h800, d, v);
      chk("R11 get ones", d, '1);
      ld(mg(8) | 32'hF00, d, v);
      chk("R11 set ones", d, '1);
      st(tp(8), v);
      st(mg(8) | 32'h400, v);
      idle(4);
      chk("R11 no notify", log_n - base, 0);
      get_chk("R11 src0 untouched", 0, 2'b00);
   endtask

   task automatic t_arb;
      logic [63:0] d; logic v;
      int base;
      ld(mg(1) | 32'hC00, d, v);
      base = log_n;
      pulse(8'h13); idle(5);
      chk("R12 count", log_n - base, 3);
      chk("R12 first", log_src[base], 0);
      chk("R12 second", log_src[base + 1], 1);
      chk("R12 third", log_src[base + 2], 4);
      chk("R12 spacing a", log_cyc[base + 1] - log_cyc[base], 1);
      chk("R12 spacing b", log_cyc[base + 2] - log_cyc[base + 1], 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_trigger();
      t_merge();
      t_eoi();
      t_off();
      t_set();
      t_store_eoi();
      t_trig_page();
      t_level();
      t_oor();
      t_arb();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule